// File: doc/BRIEF.md
# One-Wire Bus Master Controller

This block is the master side of a single-wire, open-drain serial bus. Software talks to it through a small byte-wide register port. It writes a command bit to start a bus reset with presence detection, a write-0 slot, or a write-1 slot. A write-1 slot also serves as a read slot. The command bit stays set while the operation runs and clears itself when the operation ends. After that, the presence and read-data status bits in the same control byte hold the result. All bus timing is counted in microsecond ticks. A programmable divider produces these ticks from the system clock.

The block only pulls the line low or lets it go. The outside world provides the pull-up and the wired-AND with any slave devices. The line level comes back through a synchroniser and is sampled at fixed points inside each operation. A separate soft-reset register holds the engine and the status bits cleared for as long as it is set.

The register port is a plain single-cycle write strobe with a combinational read mux. It has no handshake and no back-pressure. Software must poll the command bits to see when an operation has finished.

Top module: `owm_master`

## Requirements
- R1: After `rst_n` the register port reads as follows. Address 0 (control) reads 0x00. Address 2 (divider) reads `DIV_INIT`, which defaults to 99, and any value written there reads back. Address 4 (soft reset) reads back the value of its bit 0.
- R2: Writing a control byte with bit 7 set starts a bus reset. The line is pulled low for 511 ticks and then released. Bit 7 reads 1 for 1023 ticks in total and then reads 0.
- R3: Control bit 6 (presence) is cleared when a bus reset starts. It is set when the synchronised line is low 70 ticks after the reset pulse is released. Write and read slots do not change it.
- R4: Control bit 5 starts a write-0 slot. The line is held low for 60 ticks, and the slot lasts 65 ticks, during which bit 5 reads 1. Control bit 3 is not changed by this slot.
- R5: Control bit 4 starts a write-1/read slot. The line is held low for 6 ticks, and the slot lasts 65 ticks. The line is sampled at tick 15, and bit 3 then holds that level: 1 means high.
- R6: If several command bits are set in one write, bit 7 wins over bit 5, and bit 5 wins over bit 4. Only the winning operation runs.
- R7: Control writes that arrive while an operation is running are ignored.
- R8: A tick occurs every (divider + 1) clock cycles, counted from the start of each operation. Every duration scales with this value.
- R9: While soft-reset bit 0 is 1, the running operation is aborted, the line is released, control reads 0x00 and command writes are ignored. The divider keeps its value. Clearing bit 0 makes the block usable again.
- R10: `line_drive_low` is 0 whenever no operation is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 3 | Byte address: 0 control, 2 divider, 4 soft reset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| line_drive_low | output | 1 | 1 pulls the bus low; 0 releases it |
| line_in | input | 1 | Bus level as seen at the pad |

## Verification
The bench uses a slave model that answers resets with a presence pulse and can either hold the line low or leave it high in read slots. For each operation it measures the length of the low pulse and the time until the command bit clears. A wrong tick count or a wrong divider shows up as a pulse of the wrong length.

A control write with bits 5 and 4 set while the slave returns 0 detects a priority bug: the read slot would run and overwrite bit 3. A write-0 slot that follows a read of 1 detects a write-0 slot that wrongly touches the read status. A command issued during a bus reset must not add a 60-tick low pulse. A soft reset in mid-sequence must clear the status bits, release the line and leave the divider alone.

// File: rtl/owm_pkg.sv
package owm_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_RESET = 2'd1,
    OP_WR0   = 2'd2,
    OP_WR1   = 2'd3
  } op_e;

  localparam int ADR_CTL  = 0;
  localparam int ADR_DIV  = 2;
  localparam int ADR_SRST = 4;

  localparam int BIT_RST  = 7;
  localparam int BIT_PRES = 6;
  localparam int BIT_WR0  = 5;
  localparam int BIT_WR1  = 4;
  localparam int BIT_RD   = 3;
endpackage

// File: rtl/owm_tick_gen.sv
module owm_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pc;

  assign tick = (pc == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (clr || restart || tick) begin
      pc <= '0;
    end else begin
      pc <= pc + 1'b1;
    end
  end
endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
  import owm_pkg::*;
#(
  parameter int RST_LOW_US = 511,
  parameter int RST_ALL_US = 1023,
  parameter int PRES_DLY_US = 70,
  parameter int WR1_LOW_US = 6,
  parameter int RD_AT_US = 15,
  parameter int WR0_LOW_US = 60,
  parameter int SLOT_US = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  input  op_e  start_op,
  input  logic tick,
  input  logic line_lvl,
  output logic busy,
  output op_e  op,
  output logic drive_low,
  output logic smp_valid,
  output logic smp_val
);
  localparam int CNT_W = $clog2(RST_ALL_US + 1);
  localparam logic [CNT_W-1:0] K_RST_LOW = CNT_W'(RST_LOW_US);
  localparam logic [CNT_W-1:0] K_RST_END = CNT_W'(RST_ALL_US - 1);
  localparam logic [CNT_W-1:0] K_PRES_AT = CNT_W'(RST_LOW_US + PRES_DLY_US);
  localparam logic [CNT_W-1:0] K_WR1_LOW = CNT_W'(WR1_LOW_US);
  localparam logic [CNT_W-1:0] K_RD_AT   = CNT_W'(RD_AT_US);
  localparam logic [CNT_W-1:0] K_WR0_LOW = CNT_W'(WR0_LOW_US);
  localparam logic [CNT_W-1:0] K_SLOT_END = CNT_W'(SLOT_US - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] low_len, end_pt, smp_pt;
  logic             smp_en;

  assign busy = (op != OP_NONE);

  always_comb begin
    low_len = '0;
    end_pt  = K_SLOT_END;
    smp_pt  = '0;
    smp_en  = 1'b0;
    case (op)
      OP_RESET: begin
        low_len = K_RST_LOW;
        end_pt  = K_RST_END;
        smp_pt  = K_PRES_AT;
        smp_en  = 1'b1;
      end
      OP_WR0: low_len = K_WR0_LOW;
      OP_WR1: begin
        low_len = K_WR1_LOW;
        smp_pt  = K_RD_AT;
        smp_en  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op  <= OP_NONE;
      cnt <= '0;
    end else if (clr) begin
      op  <= OP_NONE;
      cnt <= '0;
    end else if (!busy) begin
      if (start) begin
        op  <= start_op;
        cnt <= '0;
      end
    end else if (tick) begin
      if (cnt == end_pt) begin
        op  <= OP_NONE;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign drive_low = busy && (cnt < low_len);
  assign smp_valid = busy && tick && smp_en && (cnt == smp_pt);
  assign smp_val   = line_lvl;
endmodule

// File: rtl/owm_line_io.sv
module owm_line_io #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic drive_low_d,
  input  logic line_in,
  output logic line_drive_low,
  output logic line_lvl
);
  logic [SYNC_STAGES-1:0] sh;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= line_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[SYNC_STAGES-2:0], line_in};
      end
    end
  endgenerate

  assign line_lvl = sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   line_drive_low <= 1'b0;
    else if (clr) line_drive_low <= 1'b0;
    else          line_drive_low <= drive_low_d;
  end
endmodule

// File: rtl/owm_master.sv
module owm_master
  import owm_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DIV_W = 8,
  parameter int DIV_INIT = 99,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              line_drive_low,
  input  logic              line_in
);
  logic [DIV_W-1:0] div_q;
  logic             srst_q, pres_q, rdst_q;
  logic             wr_ctl, start, tick, busy, drive_d, line_lvl;
  logic             smp_valid, smp_val;
  op_e              start_op, eng_op;
  logic [REG_W-1:0] ctl_byte;

  assign wr_ctl = reg_wr && (reg_addr == ADDR_W'(ADR_CTL));

  always_comb begin
    if (reg_wdata[BIT_RST])      start_op = OP_RESET;
    else if (reg_wdata[BIT_WR0]) start_op = OP_WR0;
    else if (reg_wdata[BIT_WR1]) start_op = OP_WR1;
    else                         start_op = OP_NONE;
  end

  assign start = wr_ctl && !busy && !srst_q && (start_op != OP_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(DIV_INIT);
      srst_q <= 1'b0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_W'(ADR_DIV))  div_q  <= reg_wdata[DIV_W-1:0];
      if (reg_addr == ADDR_W'(ADR_SRST)) srst_q <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_q <= 1'b0;
      rdst_q <= 1'b0;
    end else if (srst_q) begin
      pres_q <= 1'b0;
      rdst_q <= 1'b0;
    end else if (start) begin
      if (start_op == OP_RESET) pres_q <= 1'b0;
      if (start_op == OP_WR1)   rdst_q <= 1'b0;
    end else if (smp_valid) begin
      if (eng_op == OP_RESET) pres_q <= ~smp_val;
      if (eng_op == OP_WR1)   rdst_q <= smp_val;
    end
  end

  owm_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(srst_q), .restart(start),
    .div(div_q), .tick(tick)
  );

  owm_slot_engine u_eng (
    .clk(clk), .rst_n(rst_n), .clr(srst_q), .start(start),
    .start_op(start_op), .tick(tick), .line_lvl(line_lvl),
    .busy(busy), .op(eng_op), .drive_low(drive_d),
    .smp_valid(smp_valid), .smp_val(smp_val)
  );

  owm_line_io #(.SYNC_STAGES(SYNC_STAGES)) u_io (
    .clk(clk), .rst_n(rst_n), .clr(srst_q), .drive_low_d(drive_d),
    .line_in(line_in), .line_drive_low(line_drive_low), .line_lvl(line_lvl)
  );

  always_comb begin
    ctl_byte           = '0;
    ctl_byte[BIT_RST]  = (eng_op == OP_RESET);
    ctl_byte[BIT_PRES] = pres_q;
    ctl_byte[BIT_WR0]  = (eng_op == OP_WR0);
    ctl_byte[BIT_WR1]  = (eng_op == OP_WR1);
    ctl_byte[BIT_RD]   = rdst_q;
  end

  always_comb begin
    if (reg_addr == ADDR_W'(ADR_CTL))       reg_rdata = ctl_byte;
    else if (reg_addr == ADDR_W'(ADR_DIV))  reg_rdata = REG_W'(div_q);
    else if (reg_addr == ADDR_W'(ADR_SRST)) reg_rdata = REG_W'(srst_q);
    else                                    reg_rdata = '0;
  end
endmodule

// File: rtl/owm_master_chk.sv
module owm_master_chk #(
  parameter int ADDR_W = 3,
  parameter int DIV_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              busy,
  input logic [1:0]        op,
  input logic              srst,
  input logic              pres,
  input logic              line_drive_low,
  input logic              tick,
  input logic [DIV_W-1:0]  div
);
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == '0) && ((reg_wdata & 8'hB0) != 8'h00) && !busy && !srst
    |=> busy); // R2

  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr && (reg_addr == '0)
    |=> (op == $past(op)) || (op == 2'd0)); // R7

  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    srst && $past(srst) |-> !line_drive_low && !busy && !pres); // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> !line_drive_low); // R10

  AST_PRES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 2'd1) && ($past(op) != 2'd1) && !$past(srst) |-> $stable(pres)); // R3

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (div != '0) && $stable(div) |=> !tick); // R8
endmodule

bind owm_master owm_master_chk #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .op(eng_op), .srst(srst_q),
  .pres(pres_q), .line_drive_low(line_drive_low), .tick(tick), .div(div_q)
);

// File: tb/owm_master_test.sv
module owm_master_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       line_drive_low;
  wire        line_in;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  owm_master uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_drive_low(line_drive_low), .line_in(line_in)
  );

  // slave model: presence after long low pulses, optional 0 in read slots
  int  us_cyc = 100;
  bit  sl_present = 1'b1;
  bit  sl_bit = 1'b1;
  int  low_run = 0;
  int  hold = 0;
  int  wait_p = 0;
  logic prev_drv = 1'b0;

  assign line_in = ~(line_drive_low | (hold != 0));

  always @(posedge clk) begin
    prev_drv <= line_drive_low;
    low_run  <= line_drive_low ? low_run + 1 : 0;
    if (hold > 0) hold <= hold - 1;
    if (wait_p > 0) begin
      wait_p <= wait_p - 1;
      if (wait_p == 1) hold <= 120 * us_cyc;
    end
    if (line_drive_low && !prev_drv && !sl_bit && hold == 0 && wait_p == 0)
      hold <= 30 * us_cyc;
    if (!line_drive_low && prev_drv && low_run >= 400 * us_cyc && sl_present)
      wait_p <= 20 * us_cyc;
  end

  // count of master low cycles
  bit low_clr = 1'b0;
  int low_cnt = 0;
  always @(posedge clk) begin
    if (low_clr) low_cnt <= 0;
    else if (line_drive_low) low_cnt <= low_cnt + 1;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_rng(input string tag, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic clear_low();
    @(negedge clk); low_clr = 1'b1;
    @(negedge clk); low_clr = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    logic [7:0] d;
    cyc = 0;
    for (int k = 0; k < 8000; k++) begin
      rd(3'd0, d);
      cyc++;
      if ((d & 8'hB0) == 8'h00) break;
    end
  endtask

  function automatic string tag_of(input logic [7:0] cmd);
    if (cmd[7])            return "R2/R3 reset";
    else if (cmd == 8'h30) return "R6 priority";
    else if (cmd[5])       return "R4 write0";
    else                   return "R5 read";
  endfunction

  typedef struct packed {
    logic [7:0] cmd;
    logic       pres;
    logic       bitv;
    logic [7:0] exp_ctl;
    logic [9:0] low_us;
    logic [10:0] all_us;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{8'h80, 1'b1, 1'b1, 8'h40, 10'd511, 11'd1023},
    '{8'h80, 1'b0, 1'b1, 8'h00, 10'd511, 11'd1023},
    '{8'h10, 1'b1, 1'b1, 8'h08, 10'd6,   11'd65},
    '{8'h10, 1'b1, 1'b0, 8'h00, 10'd6,   11'd65},
    '{8'h10, 1'b1, 1'b1, 8'h08, 10'd6,   11'd65},
    '{8'h20, 1'b1, 1'b1, 8'h08, 10'd60,  11'd65},
    '{8'h30, 1'b1, 1'b0, 8'h08, 10'd60,  11'd65},
    '{8'hB0, 1'b1, 1'b1, 8'h48, 10'd511, 11'd1023},
    '{8'h10, 1'b1, 1'b0, 8'h40, 10'd6,   11'd65}
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R10 idle line
    rd(3'd0, d); check("R1 control after reset", d, 8'h00);
    rd(3'd2, d); check("R1 divider after reset", d, 99);
    rd(3'd4, d); check("R1 soft reset after reset", d, 8'h00);
    check("R10 line released at idle", line_drive_low, 0);

    wr(3'd2, 8'd0); us_cyc = 1;
    rd(3'd2, d); check("R1 divider readback", d, 8'h00);

    // vector table
    foreach (VECS[i]) begin
      sl_present = VECS[i].pres;
      sl_bit     = VECS[i].bitv;
      clear_low();
      wr(3'd0, VECS[i].cmd);
      wait_idle(cyc);
      rd(3'd0, d);
      check({tag_of(VECS[i].cmd), " status"}, d, VECS[i].exp_ctl);
      check({tag_of(VECS[i].cmd), " low ticks"}, low_cnt, VECS[i].low_us);
      check_rng({tag_of(VECS[i].cmd), " busy ticks"}, cyc,
                VECS[i].all_us - 2, VECS[i].all_us + 3);
    end
    check("R10 line released after table", line_drive_low, 0);

    // R7: command during busy ignored
    sl_present = 1'b1; sl_bit = 1'b1;
    clear_low();
    wr(3'd0, 8'h80);
    repeat (20) @(negedge clk);
    wr(3'd0, 8'h20);
    rd(3'd0, d); check("R7 control during busy", d, 8'h80);
    wait_idle(cyc);
    check("R7 no extra slot low ticks", low_cnt, 511);
    rd(3'd0, d); check("R7 presence after busy write", d, 8'h40);

    // R8: divider of 3 gives 4-cycle ticks
    wr(3'd2, 8'd3); us_cyc = 4;
    rd(3'd2, d); check("R8 divider readback", d, 8'h03);
    clear_low();
    wr(3'd0, 8'h20);
    wait_idle(cyc);
    check("R8 write0 low cycles", low_cnt, 240);
    check_rng("R8 write0 busy cycles", cyc, 258, 263);
    sl_bit = 1'b0;
    clear_low();
    wr(3'd0, 8'h10);
    wait_idle(cyc);
    check("R8 read low cycles", low_cnt, 24);
    rd(3'd0, d); check("R8 read of 0 at slow tick", d & 8'h08, 8'h00);
    sl_bit = 1'b1;
    wr(3'd0, 8'h10);
    wait_idle(cyc);
    rd(3'd0, d); check("R8 read of 1 at slow tick", d, 8'h48);
    wr(3'd2, 8'd0); us_cyc = 1;

    // R9: soft reset aborts and blocks
    wr(3'd0, 8'h80);
    repeat (50) @(negedge clk);
    wr(3'd4, 8'h01);
    repeat (3) @(negedge clk);
    rd(3'd0, d); check("R9 control cleared in soft reset", d, 8'h00);
    check("R9 line released in soft reset", line_drive_low, 0);
    rd(3'd4, d); check("R9 soft reset readback", d, 8'h01);
    clear_low();
    wr(3'd0, 8'h10);
    repeat (10) @(negedge clk);
    rd(3'd0, d); check("R9 command ignored in soft reset", d, 8'h00);
    check("R9 no low while held", low_cnt, 0);
    rd(3'd2, d); check("R9 divider kept", d, 8'h00);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h10);
    wait_idle(cyc);
    rd(3'd0, d); check("R9 usable after release", d, 8'h08);
    check("R10 line released at end", line_drive_low, 0);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule